// File: doc/BRIEF.md
# Eight-bit addressable latch and demultiplexer

This block holds eight single-bit values that share one data input. A 3-bit address picks one of the eight positions. Two active-low controls, a latch enable and a clear, choose one of four modes. In write mode the addressed bit is loaded, and the others keep their values. In hold mode every bit is frozen. In demultiplexer mode the data bit is steered to the addressed output, and all other outputs are low. In clear mode everything is zero. All eight outputs are visible at once, so a run of addressed single-bit writes turns a serial stream into a parallel byte.

The storage is built from flip-flops on a system clock rather than transparent latches. In write mode the addressed output shows the data input in the same cycle, and the stored bit captures it at the next rising edge. Demultiplexer outputs are combinational and bypass the storage, which keeps its contents through that mode.

Top module: `addr_latch_demux`

## Requirements
- R1: With latchEnN=0 and clearN=1 (write mode), output bit q[addr] equals dataIn in the same cycle, and every other output bit shows its stored value.
- R2: At a rising clock edge in write mode, only the stored bit at position addr takes the value of dataIn; the other seven stored bits are unchanged.
- R3: With latchEnN=1 and clearN=1 (hold mode), q shows the stored bits, and no change of dataIn or addr alters q or the storage.
- R4: With latchEnN=0 and clearN=0 (demultiplexer mode), q[addr] equals dataIn and all other bits of q are 0.
- R5: Demultiplexer mode leaves the stored bits untouched, so hold mode afterwards shows the same byte as hold mode before.
- R6: With latchEnN=1 and clearN=0 (clear mode), q is all zeros whatever dataIn and addr are.
- R7: A rising edge in clear mode sets all stored bits to 0, so a following hold mode shows zero.
- R8: Address value k selects output bit k, for k from 0 to 7, in both write and demultiplexer modes.
- R9: Eight write-mode cycles at addresses 0 to 7 with data b0..b7 load the byte b7..b0 onto q.
- R10: While the system reset rstN is low, the storage is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; storage updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low system reset of the storage |
| dataIn | input | 1 | Serial data bit |
| addr | input | 3 | Selected bit position |
| latchEnN | input | 1 | Active-low latch enable |
| clearN | input | 1 | Active-low clear |
| q | output | 8 | Parallel outputs |

## Verification
Walking single-one and single-zero patterns across all eight addresses show whether decoding is correct and whether a write disturbs neighbouring bits. A mixed serial byte loaded bit by bit, followed by demultiplexer bursts at every address, separates the storage path from the decoder path. It also shows whether the demultiplexer mode corrupts stored contents. Hold and clear cycles with dataIn and addr toggling show whether those modes really ignore their inputs, and whether clear reaches both the outputs and the stored state.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE,
    MODE_HOLD,
    MODE_DEMUX,
    MODE_CLEAR
  } latchMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic writeBit;    // capture dataIn into addressed storage bit
    logic clearAll;    // zero storage and outputs
    logic passDemux;   // outputs come from decoder path
    logic overlayBit;  // addressed output follows dataIn over storage
  } latchStrobes_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic          latchEnN,
  input  logic          clearN,
  output latchStrobes_t strobes
);

  latchMode_t mode;

  always_comb begin
    unique case ({latchEnN, clearN})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.writeBit   = (mode == MODE_WRITE);
    strobes.overlayBit = (mode == MODE_WRITE);
    strobes.passDemux  = (mode == MODE_DEMUX);
    strobes.clearAll   = (mode == MODE_CLEAR);
  end

endmodule

// File: rtl/addr_latch_datapath.sv
module addr_latch_datapath
  import addr_latch_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  latchStrobes_t     strobes,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addr,
  output logic [WIDTH-1:0]  q
);

  logic [WIDTH-1:0] bitSel;
  logic [WIDTH-1:0] stored;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitSel[i] = (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stored[i] <= 1'b0;
      end else if (strobes.clearAll) begin
        stored[i] <= 1'b0;
      end else if (strobes.writeBit && bitSel[i]) begin
        stored[i] <= dataIn;
      end
    end

    always_comb begin
      if (strobes.clearAll) begin
        q[i] = 1'b0;
      end else if (strobes.passDemux) begin
        q[i] = bitSel[i] & dataIn;
      end else if (strobes.overlayBit && bitSel[i]) begin
        q[i] = dataIn;
      end else begin
        q[i] = stored[i];
      end
    end
  end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int ADDR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              latchEnN,
  input  logic              clearN,
  output logic [WIDTH-1:0]  q
);

  latchStrobes_t strobes;

  addr_latch_ctrl u_ctrl (
    .latchEnN (latchEnN),
    .clearN   (clearN),
    .strobes  (strobes)
  );

  addr_latch_datapath #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .addr    (addr),
    .q       (q)
  );

endmodule

// File: rtl/addr_latch_checker.sv
module addr_latch_checker #(
  parameter int WIDTH = 8,
  localparam int ADDR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataIn,
  input logic [ADDR_W-1:0] addr,
  input logic              latchEnN,
  input logic              clearN,
  input logic [WIDTH-1:0]  q
);

  logic isWrite, isHold, isDemux, isClear;
  assign isWrite = !latchEnN &&  clearN;
  assign isHold  =  latchEnN &&  clearN;
  assign isDemux = !latchEnN && !clearN;
  assign isClear =  latchEnN && !clearN;

  assert_write_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    isWrite |-> q[addr] == dataIn);

  assert_write_captured_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isWrite) && isHold) |-> q[$past(addr)] == $past(dataIn));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isHold) && isHold) |-> $stable(q));

  assert_demux_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    isDemux |-> (q[addr] == dataIn) && $onehot0(q));

  assert_demux_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isHold, 2) && $past(isDemux) && isHold) |-> q == $past(q, 2));

  assert_clear_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    isClear |-> q == '0);

  assert_clear_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isClear) && isHold) |-> q == '0);

endmodule

bind addr_latch_demux addr_latch_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataIn   (dataIn),
  .addr     (addr),
  .latchEnN (latchEnN),
  .clearN   (clearN),
  .q        (q)
);

// File: tb/sim_addr_latch_demux.sv
`timescale 1ns/100ps
module sim_addr_latch_demux;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataIn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       latchEnN = 1'b1;
  logic       clearN = 1'b1;
  logic [7:0] q;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;
  bit [7:0] refMem = 8'h00;
  bit [7:0] snap;

  always #2 clk = ~clk;

  addr_latch_demux u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .addr(addr),
    .latchEnN(latchEnN), .clearN(clearN), .q(q)
  );

  task automatic check(string tag, logic [7:0] exp);
    vectors++;
    if (q !== exp) begin
      misses++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  // one cycle: drive after edge, compare mid-cycle, advance model to next edge
  task automatic step(string tag, bit le, bit cl, bit d, int a);
    bit [7:0] e;
    @(posedge clk);
    #1;
    latchEnN = le; clearN = cl; dataIn = d; addr = 3'(a);
    #0.5;
    case ({le, cl})
      2'b01: begin e = refMem; e[a] = d; end
      2'b11: e = refMem;
      2'b00: begin e = 8'h00; e[a] = d; end
      default: e = 8'h00;
    endcase
    check(tag, e);
    if ({le, cl} == 2'b01) refMem[a] = d;
    if ({le, cl} == 2'b10) refMem = 8'h00;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: q=%b expected run end", q);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit [7:0] pattern;
    repeat (3) @(posedge clk);
    #1; check("R10 reset state", 8'h00);
    rstN = 1'b1;
    step("R3 hold after reset", 1, 1, 1, 5);

    // R8 R1 R2: walking one, then walking zero
    for (int a = 0; a < 8; a++) begin
      step("R1 R8 walk one write", 0, 1, 1, a);
      step("R2 R8 walk one clear bit", 0, 1, 0, a);
      step("R2 hold", 1, 1, 0, 0);
    end
    for (int a = 0; a < 8; a++) step("R2 fill ones", 0, 1, 1, a);
    for (int a = 0; a < 8; a++) begin
      step("R1 R8 walk zero", 0, 1, 0, a);
      step("R2 restore", 0, 1, 1, a);
    end

    // R9 serial load
    pattern = 8'b1011_0010;
    for (int a = 0; a < 8; a++) step("R9 serial", 0, 1, pattern[a], a);
    step("R9 loaded byte", 1, 1, 0, 3);
    check("R9 byte value", pattern);

    // R3 hold ignores data/address
    for (int a = 0; a < 8; a++) step("R3 hold ignores", 1, 1, a[0], 7 - a);

    // R4 R8 demux, then R5 storage intact
    snap = refMem;
    for (int a = 0; a < 8; a++) begin
      step("R4 R8 demux one", 0, 0, 1, a);
      step("R4 demux zero", 0, 0, 0, a);
    end
    step("R5 after demux", 1, 1, 1, 2);
    check("R5 storage kept", snap);

    // R6 R7 clear
    step("R6 clear out", 1, 0, 1, 4);
    step("R6 clear ignores", 1, 0, 0, 1);
    step("R7 cleared state", 1, 1, 1, 6);
    check("R7 zero after clear", 8'h00);

    // mixed: write then reset via rstN
    step("R1 write", 0, 1, 1, 3);
    step("R1 write", 0, 1, 1, 6);
    step("R3 hold", 1, 1, 0, 0);
    check("R2 two bits", 8'b0100_1000);
    @(negedge clk); rstN = 1'b0; refMem = 8'h00;
    #1; check("R10 async reset", 8'h00);
    @(negedge clk); rstN = 1'b1;
    step("R10 hold after reset", 1, 1, 1, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule